// File: doc/BRIEF.md
# Periodic InfoFrame Packet Scheduler

This block holds the payload of an auxiliary video InfoFrame as four 32-bit words that software prepares one at a time. The words are staged: they reach the packet that goes out on the link only when software sets a commit bit in the control word. The commit copies all four staged words into a shadow buffer in one clock edge, and the bit then clears itself.

At every frame-start pulse the block decides whether a packet goes out. Sending must be enabled, and a rate bit picks either every frame or every other frame. When a packet is due, the block raises a request toward the link encoder. The request carries the shadow payload as it stood at that frame start. It stays up, with the payload held steady, until the encoder acknowledges it. A frame start that arrives while a request is still open is dropped, not queued. Data-island encoding and checksum generation sit downstream and are not part of this block.

Top module: `infoframe_sched`

## Requirements
- R1: Writing address 0, 1, 2 or 3 stores the 32-bit write data in staged word 0, 1, 2 or 3, and reading the same address returns it. Staged word n sits at payload bits [32n+31:32n].
- R2: Address 4 is the control word: bit 0 enables sending, bit 1 selects the rate and bit 2 commits. After reset the control word reads 0, every staged and shadow word is 0 and no request is raised.
- R3: A control write with bit 2 set reads back with bit 2 = 1 in the following cycle. Bit 2 then reads 0 from the cycle after that, unless it is written again.
- R4: A commit copies all four staged words into the shadow buffer on a single edge. Staged words written afterwards, or written without a commit, do not change the payload that is sent. This includes a staged write that lands on the same edge as the copy.
- R5: While the enable bit is 0, frame starts raise no request.
- R6: With enable 1 and rate bit 0, every frame start that finds no open request raises one.
- R7: With rate bit 1, only alternate enabled frame starts may raise a request. The first enabled frame start after enable goes from 0 to 1 is an allowed one.
- R8: A raised request stays high, with its payload unchanged, until the cycle in which the acknowledge input is sampled high. It drops on that edge.
- R9: A frame start that occurs while a request is open raises no second request, and none is held back for later.
- R10: The payload of a request equals the shadow buffer at the frame start that raised it. With no commit since reset, that payload is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-3 staged words, 4 control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data, 0 for unmapped addresses |
| frame_start | input | 1 | One-cycle pulse at each frame start |
| pkt_req | output | 1 | Packet send request to the encoder |
| pkt_ack | input | 1 | Encoder acknowledge of the open request |
| pkt_data | output | 128 | Payload of the open request, word 0 in the low bits |

## Verification
The properties assume that frame start and acknowledge are single-cycle pulses and that acknowledge is raised only while a request is open. Under those assumptions, "held until acknowledged" and "dropped on acknowledge" are exact statements about the request register. The stimulus drives acknowledge one cycle after it sees a request, or holds it back on purpose to keep a request open across further frame starts. It leaves idle cycles after every frame start and every register write, so the bench model and the design never race. The one exception is the commit test, which places a staged write on the very edge of the copy on purpose.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  // Control word layout as seen by software: bit 0 enable, bit 1 rate, bit 2 commit
  typedef struct packed {
    logic upd;
    logic rate;
    logic en;
  } ifs_ctrl_t;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_RATE_BIT = 1;
  localparam int unsigned CTRL_UPD_BIT  = 2;
  localparam int unsigned CTRL_W        = 3;

endpackage

// File: rtl/ifs_regfile.sv
module ifs_regfile
  import ifs_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data,
  output logic [NUM_WORDS*WORD_W-1:0] content_o,
  output ifs_ctrl_t                   ctrl_o,
  output logic                        en_rise_o
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WORDS);

  logic [NUM_WORDS-1:0][WORD_W-1:0] word_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] word_d;
  ifs_ctrl_t                        ctrl_q;
  ifs_ctrl_t                        ctrl_d;
  logic                             wr_ctrl;

  assign wr_ctrl = wr_en && (wr_addr == CTRL_ADDR);

  // staged payload words
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_comb begin
      word_d[g] = word_q[g];
      if (wr_en && (wr_addr == ADDR_W'(g))) begin
        word_d[g] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else begin
        word_q[g] <= word_d[g];
      end
    end
  end

  // control word; the commit bit lives for one cycle unless rewritten
  always_comb begin
    ctrl_d     = ctrl_q;
    ctrl_d.upd = 1'b0;
    if (wr_ctrl) begin
      ctrl_d.en   = wr_data[CTRL_EN_BIT];
      ctrl_d.rate = wr_data[CTRL_RATE_BIT];
      ctrl_d.upd  = wr_data[CTRL_UPD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign en_rise_o = wr_ctrl && wr_data[CTRL_EN_BIT] && !ctrl_q.en;
  assign content_o = word_q;
  assign ctrl_o    = ctrl_q;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        rd_data = word_q[i];
      end
    end
    if (rd_addr == CTRL_ADDR) begin
      rd_data = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
    end
  end

  // R3: commit bit self-clears when not rewritten
  a_r3_update_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.upd && !(wr_ctrl && wr_data[CTRL_UPD_BIT]) |=> !ctrl_q.upd);

endmodule

// File: rtl/ifs_shadow.sv
module ifs_shadow #(
  parameter int unsigned TOTAL_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_i,
  input  logic [TOTAL_W-1:0] content_i,
  output logic [TOTAL_W-1:0] shadow_o
);

  logic [TOTAL_W-1:0] shadow_q;
  logic [TOTAL_W-1:0] shadow_d;

  always_comb begin
    shadow_d = shadow_q;
    if (upd_i) begin
      shadow_d = content_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else begin
      shadow_q <= shadow_d;
    end
  end

  assign shadow_o = shadow_q;

  // R4: the whole buffer is replaced on one edge, and only after a commit
  a_r4_copy_whole: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> shadow_q == $past(content_i));
  a_r4_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(shadow_q));

endmodule

// File: rtl/ifs_pacer.sv
module ifs_pacer #(
  parameter int unsigned TOTAL_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start_i,
  input  logic               en_i,
  input  logic               rate_i,
  input  logic               en_rise_i,
  input  logic [TOTAL_W-1:0] shadow_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic [TOTAL_W-1:0] payload_o
);

  logic               tog_q;
  logic               tog_d;
  logic               req_q;
  logic               req_d;
  logic [TOTAL_W-1:0] payload_q;
  logic [TOTAL_W-1:0] payload_d;
  logic               allowed;
  logic               launch;

  // frame parity: reset on enable, flips on each enabled frame start
  always_comb begin
    tog_d = tog_q;
    if (en_rise_i) begin
      tog_d = 1'b0;
    end else if (frame_start_i && en_i) begin
      tog_d = !tog_q;
    end
  end

  assign allowed = en_i && (!rate_i || !tog_q);
  assign launch  = frame_start_i && allowed && !req_q;

  always_comb begin
    req_d     = req_q;
    payload_d = payload_q;
    if (req_q && ack_i) begin
      req_d = 1'b0;
    end else if (launch) begin
      req_d     = 1'b1;
      payload_d = shadow_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q     <= 1'b0;
      req_q     <= 1'b0;
      payload_q <= '0;
    end else begin
      tog_q     <= tog_d;
      req_q     <= req_d;
      payload_q <= payload_d;
    end
  end

  assign req_o     = req_q;
  assign payload_o = payload_q;

  // R8: request and payload hold until acknowledged
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !ack_i |=> req_q && $stable(payload_q));
  // R8: acknowledge closes the request
  a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && ack_i |=> !req_q);
  // R5: disabled means no new request
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i && !req_q |=> !req_q);
  // R7: odd frame in half-rate mode raises nothing
  a_r7_skip_odd: assert property (@(posedge clk) disable iff (!rst_n)
    rate_i && tog_q && !req_q |=> !req_q);
  // R6: full rate sends at every free frame start
  a_r6_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i && en_i && !rate_i && !req_q |=> req_q);

endmodule

// File: rtl/infoframe_sched.sv
module infoframe_sched
  import ifs_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned SYNC_LEN  = 2,
  localparam int unsigned TOTAL_W  = WORD_W * NUM_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               frame_start,
  output logic               pkt_req,
  input  logic               pkt_ack,
  output logic [TOTAL_W-1:0] pkt_data
);

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;
  logic [TOTAL_W-1:0]  content;
  logic [TOTAL_W-1:0]  shadow;
  ifs_ctrl_t           ctrl;
  logic                en_rise;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  ifs_regfile #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .content_o(content),
    .ctrl_o   (ctrl),
    .en_rise_o(en_rise)
  );

  ifs_shadow #(.TOTAL_W(TOTAL_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_i    (ctrl.upd),
    .content_i(content),
    .shadow_o (shadow)
  );

  ifs_pacer #(.TOTAL_W(TOTAL_W)) u_pacer (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .frame_start_i(frame_start),
    .en_i         (ctrl.en),
    .rate_i       (ctrl.rate),
    .en_rise_i    (en_rise),
    .shadow_i     (shadow),
    .ack_i        (pkt_ack),
    .req_o        (pkt_req),
    .payload_o    (pkt_data)
  );

  // R2: nothing is requested while held in reset
  a_r2_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |=> !pkt_req);

endmodule

// File: tb/infoframe_sched_tb_top.sv
module infoframe_sched_tb_top;

  localparam int W = 32;
  localparam int N = 4;
  localparam int T = W * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         frame_start = 1'b0;
  logic         pkt_req;
  logic         pkt_ack = 1'b0;
  logic [T-1:0] pkt_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit hold_ack = 1'b0;
  bit done = 1'b0;

  logic [T-1:0] exp_q[$];
  logic [T-1:0] content_m = '0;
  logic [T-1:0] shadow_m  = '0;
  bit en_m = 0, rate_m = 0, tog_m = 0;

  always #4 clk = !clk;

  infoframe_sched dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_start(frame_start),
    .pkt_req(pkt_req), .pkt_ack(pkt_ack), .pkt_data(pkt_data)
  );

  task automatic chk(input bit ok, input string rq, input logic [T-1:0] act, input logic [T-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // model of one register write
  task automatic model_wr(input logic [2:0] a, input logic [W-1:0] d);
    if (a < 3'(N)) content_m[a*W +: W] = d;
    else if (a == 3'(N)) begin
      if (d[0] && !en_m) tog_m = 0;
      en_m = d[0];
      rate_m = d[1];
      if (d[2]) shadow_m = content_m;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    model_wr(a, d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [W-1:0] exp, input string rq);
    rd_addr = a;
    #1;
    chk(rd_data == exp, rq, T'(rd_data), T'(exp));
  endtask

  // driver: one frame start, expected packet pushed to the scoreboard
  task automatic frame();
    @(negedge clk);
    frame_start = 1;
    if (en_m && (!rate_m || !tog_m) && exp_q.size() == 0) exp_q.push_back(shadow_m);
    if (en_m) tog_m = !tog_m;
    @(negedge clk);
    frame_start = 0;
    repeat (3) @(negedge clk);
    chk(pkt_req == (exp_q.size() != 0), "R9 request state after frame",
        T'(pkt_req), T'(exp_q.size() != 0));
  endtask

  // monitor: compares each request and acknowledges it
  always @(negedge clk) begin
    if (pkt_ack) begin
      pkt_ack = 0;
    end else if (pkt_req && !hold_ack && !done) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected request", pkt_data, '0);
      end else begin
        chk(pkt_data == exp_q[0], "R10 payload", pkt_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
      pkt_ack = 1;
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", '0, '1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk(pkt_req == 0, "R2 reset request", T'(pkt_req), '0);
    chk(pkt_data == '0, "R2 reset payload", pkt_data, '0);
    rd_chk(3'd4, '0, "R2 reset control");
    rd_chk(3'd2, '0, "R2 reset word");

    // R1 staged words
    for (int i = 0; i < N; i++) wr(3'(i), 32'hA0A0_0000 + 32'(i * 17));
    for (int i = 0; i < N; i++) rd_chk(3'(i), 32'hA0A0_0000 + 32'(i * 17), "R1 readback");

    // R10 enable without commit sends zeros
    wr(3'd4, 32'h1);
    frame();
    repeat (3) @(negedge clk);

    // R3 commit bit visible one cycle then clear
    wr(3'd4, 32'h5);
    rd_chk(3'd4, 32'h5, "R3 commit bit set");
    @(negedge clk);
    rd_chk(3'd4, 32'h1, "R3 commit bit cleared");

    // R6 full rate
    for (int i = 0; i < 3; i++) frame();

    // R4 staged write without commit not sent
    wr(3'd0, 32'hBBBB_0001);
    wr(3'd3, 32'hBBBB_0004);
    frame();

    // R7 half rate, enable already on: parity continues
    wr(3'd4, 32'h3);
    for (int i = 0; i < 4; i++) frame();

    // R5 disabled
    wr(3'd4, 32'h2);
    frame();
    frame();
    chk(pkt_req == 0, "R5 no request while off", T'(pkt_req), '0);

    // R7 re-enable half rate with commit: first frame sends
    wr(3'd4, 32'h7);
    for (int i = 0; i < 3; i++) frame();

    // R8/R9 hold acknowledge across frames
    wr(3'd4, 32'h1);
    hold_ack = 1;
    frame();
    frame();
    frame();
    chk(pkt_req == 1, "R8 request held", T'(pkt_req), '1);
    chk(exp_q.size() == 1, "R9 only one outstanding", T'(exp_q.size()), T'(1));
    hold_ack = 0;
    repeat (4) @(negedge clk);
    chk(pkt_req == 0, "R8 dropped after ack", T'(pkt_req), '0);
    chk(exp_q.size() == 0, "R9 nothing queued", T'(exp_q.size()), '0);

    // R4 staged write on the copy edge is not taken
    @(negedge clk);
    wr_en = 1; wr_addr = 3'd4; wr_data = 32'h5;
    model_wr(3'd4, 32'h5);
    @(negedge clk);
    wr_addr = 3'd1; wr_data = 32'hC1C1_C1C1;
    model_wr(3'd1, 32'hC1C1_C1C1);
    @(negedge clk);
    wr_en = 0;
    frame();
    rd_chk(3'd1, 32'hC1C1_C1C1, "R1 late word stored");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all packets seen", T'(exp_q.size()), '0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule